// File: doc/BRIEF.md
# Bridge Window and Bus-Number Forwarding Decoder

This block holds the routing state of a PCI-to-PCI bridge and makes the forwarding decision for every downstream request seen on the primary side. Software programs the bus numbers, an I/O window, a memory window, two enable bits and three bridge-control bits through a dword-wide configuration port with byte enables. Each request is then classified within the same cycle. A memory or I/O request is forwarded when it falls in its window or in the legacy display ranges. A type-1 configuration request is converted to type 0 when it targets the secondary bus. It is passed on unchanged when it targets a bus further downstream, and it is left alone otherwise.

The decision logic is purely combinational on the stored registers. A configuration write that lands in the same cycle as a request only takes effect from the next cycle on. The memory window uses a 1 MB granule: the register holds address bits 31:16, and its low nibble is fixed at zero. The I/O window uses a 4 KB granule and covers the 16-bit I/O space.

Top module: `pci_brg_fwd`

## Requirements
- R1: After reset every stored field is zero, `fwd_o`, `cfg_t0_o`, `cfg_t1_o` and `sec_rst_o` are low, and every readback is zero.
- R2: Dword index 1 holds the I/O enable (bit 0) and the memory enable (bit 1). Index 6 holds the primary bus (bits 7:0), the secondary bus (15:8) and the subordinate bus (23:16). Index 7 holds the I/O base in bits 7:4 and the I/O limit in bits 15:12. Index 8 holds the memory base in bits 15:4 and the memory limit in bits 31:20. Index 15 holds the alias-suppress bit (18), the display-forward bit (19) and the secondary-reset bit (22). Each byte is written only when its byte enable is set. Every other bit and every other index reads zero.
- R3: The low nibbles of the I/O base and limit read 0, which marks 16-bit I/O decoding. The low nibbles of the memory base and limit also read 0. Writes to these nibbles have no effect.
- R4: A memory request (`req_type_i`=0) is forwarded when the memory enable is set and base[15:4]·1 MB ≤ address ≤ limit[15:4]·1 MB + 0xFFFFF.
- R5: An I/O request (`req_type_i`=1) is forwarded when the I/O enable is set, address bits 31:16 are zero, and address bits 15:12 lie from the base nibble to the limit nibble inclusive.
- R6: A base above its limit opens no window for that space.
- R7: With the alias-suppress bit set, an I/O address inside the window whose bits 9:8 are nonzero is not forwarded, unless it is a display address (R8).
- R8: With the display-forward bit set, memory 0xA0000–0xBFFFF and I/O 0x3B0–0x3BB and 0x3C0–0x3DF are forwarded whenever the matching enable is set, regardless of the windows and of R7.
- R9: A type-1 configuration request (`req_type_i`=2) asserts `cfg_t0_o` when its bus equals the secondary bus. It asserts `cfg_t1_o` when its bus lies above the secondary bus and at or below the subordinate bus. In any other case it asserts neither output.
- R10: While the secondary bus number is not above the primary bus number, no configuration request is claimed.
- R11: `sec_rst_o` follows the secondary-reset bit.
- R12: With `req_valid_i` low, or with `req_type_i`=3, all three decision outputs are low. A decision uses the register values held before any configuration write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_dw_i | input | 6 | Dword index into configuration space |
| cfg_be_i | input | 4 | Byte enables for the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Readback of the addressed dword |
| req_valid_i | input | 1 | Request present |
| req_type_i | input | 2 | 0 memory, 1 I/O, 2 type-1 config, 3 none |
| req_addr_i | input | 32 | Memory or I/O address |
| req_bus_i | input | 8 | Target bus of a configuration request |
| fwd_o | output | 1 | Memory or I/O request forwarded |
| cfg_t0_o | output | 1 | Config request converted to type 0 |
| cfg_t1_o | output | 1 | Config request passed on as type 1 |
| sec_rst_o | output | 1 | Secondary bus reset |

## Verification
A configuration write and a request decision can fall in the same cycle. The interesting case is a write that opens or moves a window, or renumbers the buses, while a request aimed at the new setting is already present. The bench drives both in one cycle and samples the decision before the clock edge. It expects the verdict computed from the old register model. It then repeats the request in the next cycle and expects the verdict from the updated model. The random phase mixes writes and requests in every cycle, so this overlap also comes up many times with random values.

// File: rtl/pci_brg_pkg.sv
package pci_brg_pkg;
  localparam int ADDR_W  = 32;
  localparam int BUS_W   = 8;
  localparam int DATA_W  = 32;
  localparam int DW_W    = 6;
  localparam int IO_FW   = 4;
  localparam int IO_LSB  = 12;
  localparam int MEM_FW  = 12;
  localparam int MEM_LSB = 20;

  localparam logic [DW_W-1:0] DW_CMD  = 6'd1;
  localparam logic [DW_W-1:0] DW_BUS  = 6'd6;
  localparam logic [DW_W-1:0] DW_IO   = 6'd7;
  localparam logic [DW_W-1:0] DW_MEM  = 6'd8;
  localparam logic [DW_W-1:0] DW_CTL  = 6'd15;

  typedef enum logic [1:0] {
    REQ_MEM  = 2'd0,
    REQ_IO   = 2'd1,
    REQ_CFG1 = 2'd2,
    REQ_NONE = 2'd3
  } req_kind_e;

  typedef struct packed {
    logic              io_en;
    logic              mem_en;
    logic [BUS_W-1:0]  pri;
    logic [BUS_W-1:0]  sec;
    logic [BUS_W-1:0]  sub;
    logic [IO_FW-1:0]  io_base;
    logic [IO_FW-1:0]  io_lim;
    logic [MEM_FW-1:0] mem_base;
    logic [MEM_FW-1:0] mem_lim;
    logic              isa_sup;
    logic              vga_fwd;
    logic              sec_rst;
  } brg_cfg_t;
endpackage

// File: rtl/pci_brg_regs.sv
module pci_brg_regs
  import pci_brg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DW_W-1:0]   dw_i,
  input  logic [3:0]        be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output brg_cfg_t          cfg_o
);
  brg_cfg_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (wr_i) begin
      case (dw_i)
        DW_CMD: if (be_i[0]) {q.mem_en, q.io_en} <= wdata_i[1:0];
        DW_BUS: begin
          if (be_i[0]) q.pri <= wdata_i[7:0];
          if (be_i[1]) q.sec <= wdata_i[15:8];
          if (be_i[2]) q.sub <= wdata_i[23:16];
        end
        DW_IO: begin
          if (be_i[0]) q.io_base <= wdata_i[7:4];
          if (be_i[1]) q.io_lim  <= wdata_i[15:12];
        end
        DW_MEM: begin
          if (be_i[0]) q.mem_base[3:0]  <= wdata_i[7:4];
          if (be_i[1]) q.mem_base[11:4] <= wdata_i[15:8];
          if (be_i[2]) q.mem_lim[3:0]   <= wdata_i[23:20];
          if (be_i[3]) q.mem_lim[11:4]  <= wdata_i[31:24];
        end
        DW_CTL: if (be_i[2]) begin
          q.sec_rst <= wdata_i[22];
          q.vga_fwd <= wdata_i[19];
          q.isa_sup <= wdata_i[18];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (dw_i)
      DW_CMD: rdata_o = {30'h0, q.mem_en, q.io_en};
      DW_BUS: rdata_o = {8'h0, q.sub, q.sec, q.pri};
      DW_IO:  rdata_o = {16'h0, q.io_lim, 4'h0, q.io_base, 4'h0};
      DW_MEM: rdata_o = {q.mem_lim, 4'h0, q.mem_base, 4'h0};
      DW_CTL: rdata_o = {9'h0, q.sec_rst, 2'h0, q.vga_fwd, q.isa_sup, 18'h0};
      default: rdata_o = '0;
    endcase
  end

  assign cfg_o = q;

  assert_sec_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && dw_i == DW_BUS && be_i[1]) |=> (cfg_o.sec == $past(wdata_i[15:8])));
  assert_masked_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && dw_i == DW_BUS && !be_i[0]) |=> $stable(cfg_o.pri));
endmodule

// File: rtl/pci_brg_win.sv
module pci_brg_win #(
  parameter int AW  = 32,
  parameter int LSB = 20,
  parameter int FW  = 12
) (
  input  logic [AW-1:0] addr_i,
  input  logic [FW-1:0] base_i,
  input  logic [FW-1:0] lim_i,
  output logic          hit_o
);
  localparam int TOP = LSB + FW;
  logic [FW-1:0] fld;
  logic          upper_ok;

  assign fld = addr_i[TOP-1:LSB];

  generate
    if (TOP < AW) begin : g_upper
      assign upper_ok = (addr_i[AW-1:TOP] == '0);
    end else begin : g_full
      assign upper_ok = 1'b1;
    end
  endgenerate

  assign hit_o = upper_ok && (fld >= base_i) && (fld <= lim_i);
endmodule

// File: rtl/pci_brg_route.sv
module pci_brg_route #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic [BW-1:0] bus_i,
  input  logic [BW-1:0] pri_i,
  input  logic [BW-1:0] sec_i,
  input  logic [BW-1:0] sub_i,
  output logic          t0_o,
  output logic          t1_o
);
  logic live;
  assign live = act_i && (sec_i > pri_i);
  assign t0_o = live && (bus_i == sec_i);
  assign t1_o = live && (bus_i > sec_i) && (bus_i <= sub_i);

  assert_t1_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t1_o |-> (bus_i != sec_i) && (bus_i <= sub_i));
  assert_numbering_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_i <= pri_i) |-> !(t0_o || t1_o));
endmodule

// File: rtl/pci_brg_fwd.sv
module pci_brg_fwd
  import pci_brg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [DW_W-1:0]   cfg_dw_i,
  input  logic [3:0]        cfg_be_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              req_valid_i,
  input  logic [1:0]        req_type_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BUS_W-1:0]  req_bus_i,
  output logic              fwd_o,
  output logic              cfg_t0_o,
  output logic              cfg_t1_o,
  output logic              sec_rst_o
);
  brg_cfg_t cfg;
  logic mem_hit, io_hit, vga_mem, vga_io, alias_blk, mem_fwd, io_fwd;
  logic is_mem, is_io, is_cfg;

  pci_brg_regs u_regs (
    .clk_i, .rst_ni,
    .wr_i(cfg_wr_i), .dw_i(cfg_dw_i), .be_i(cfg_be_i),
    .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o), .cfg_o(cfg)
  );

  pci_brg_win #(.AW(ADDR_W), .LSB(MEM_LSB), .FW(MEM_FW)) u_mem_win (
    .addr_i(req_addr_i), .base_i(cfg.mem_base), .lim_i(cfg.mem_lim), .hit_o(mem_hit)
  );

  pci_brg_win #(.AW(ADDR_W), .LSB(IO_LSB), .FW(IO_FW)) u_io_win (
    .addr_i(req_addr_i), .base_i(cfg.io_base), .lim_i(cfg.io_lim), .hit_o(io_hit)
  );

  assign is_mem = req_valid_i && (req_type_i == REQ_MEM);
  assign is_io  = req_valid_i && (req_type_i == REQ_IO);
  assign is_cfg = req_valid_i && (req_type_i == REQ_CFG1);

  // legacy display ranges
  assign vga_mem = cfg.vga_fwd && (req_addr_i[ADDR_W-1:17] == 15'h5);
  assign vga_io  = cfg.vga_fwd &&
                   (((req_addr_i >= 32'h3B0) && (req_addr_i <= 32'h3BB)) ||
                    ((req_addr_i >= 32'h3C0) && (req_addr_i <= 32'h3DF)));
  assign alias_blk = cfg.isa_sup && (req_addr_i[9:8] != 2'b00);

  assign mem_fwd = cfg.mem_en && (mem_hit || vga_mem);
  assign io_fwd  = cfg.io_en && ((io_hit && !alias_blk) || vga_io);
  assign fwd_o   = (is_mem && mem_fwd) || (is_io && io_fwd);

  pci_brg_route #(.BW(BUS_W)) u_route (
    .clk_i, .rst_ni,
    .act_i(is_cfg), .bus_i(req_bus_i),
    .pri_i(cfg.pri), .sec_i(cfg.sec), .sub_i(cfg.sub),
    .t0_o(cfg_t0_o), .t1_o(cfg_t1_o)
  );

  assign sec_rst_o = cfg.sec_rst;

  assert_mem_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_o && req_type_i == REQ_MEM) |-> cfg.mem_en);
  assert_io_upper_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_o && req_type_i == REQ_IO) |-> (cfg.io_en && req_addr_i[31:16] == 16'h0));
  assert_alias_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_o && req_type_i == REQ_IO && cfg.isa_sup && req_addr_i[9:8] != 2'b00)
      |-> (cfg.vga_fwd && req_addr_i[15:10] == 6'h0));
  assert_cfg_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_t0_o && cfg_t1_o));
  assert_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !(fwd_o || cfg_t0_o || cfg_t1_o));
endmodule

// File: tb/pci_brg_fwd_bench.sv
module pci_brg_fwd_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [5:0]  cfg_dw_i = '0;
  logic [3:0]  cfg_be_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_type_i = 2'd3;
  logic [31:0] req_addr_i = '0;
  logic [7:0]  req_bus_i = '0;
  logic        fwd_o, cfg_t0_o, cfg_t1_o, sec_rst_o;

  int total = 0;
  int bad = 0;

  // bench model
  logic [1:0]  m_cmd;
  logic [7:0]  m_pri, m_sec, m_sub;
  logic [3:0]  m_iob, m_iol;
  logic [11:0] m_mb, m_ml;
  logic        m_isa, m_vga, m_rst;

  always #2.5 clk_i = ~clk_i;

  pci_brg_fwd u_pci_brg_fwd (.*);

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: run did not complete");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [31:0] exp_rd(input logic [5:0] dw);
    case (dw)
      6'd1:  return {30'h0, m_cmd};
      6'd6:  return {8'h0, m_sub, m_sec, m_pri};
      6'd7:  return {16'h0, m_iol, 4'h0, m_iob, 4'h0};
      6'd8:  return {m_ml, 4'h0, m_mb, 4'h0};
      6'd15: return {9'h0, m_rst, 2'h0, m_vga, m_isa, 18'h0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_fwd(input logic v, input logic [1:0] t, input logic [31:0] a);
    logic win, vga;
    if (!v) return 1'b0;
    if (t == 2'd0) begin
      win = (a >= {m_mb, 20'h0}) && (a <= {m_ml, 20'hFFFFF});
      vga = m_vga && (a >= 32'hA0000) && (a <= 32'hBFFFF);
      return m_cmd[1] && (win || vga);
    end
    if (t == 2'd1) begin
      win = (a[31:16] == 0) && (a[15:12] >= m_iob) && (a[15:12] <= m_iol)
            && !(m_isa && a[9:8] != 0);
      vga = m_vga && ((a >= 32'h3B0 && a <= 32'h3BB) || (a >= 32'h3C0 && a <= 32'h3DF));
      return m_cmd[0] && (win || vga);
    end
    return 1'b0;
  endfunction

  function automatic logic [1:0] exp_cfg(input logic v, input logic [1:0] t, input logic [7:0] b);
    if (!v || t != 2'd2 || m_sec <= m_pri) return 2'b00;
    if (b == m_sec) return 2'b01;
    if (b > m_sec && b <= m_sub) return 2'b10;
    return 2'b00;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_wr(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
    case (dw)
      6'd1: if (be[0]) m_cmd = d[1:0];
      6'd6: begin
        if (be[0]) m_pri = d[7:0];
        if (be[1]) m_sec = d[15:8];
        if (be[2]) m_sub = d[23:16];
      end
      6'd7: begin
        if (be[0]) m_iob = d[7:4];
        if (be[1]) m_iol = d[15:12];
      end
      6'd8: begin
        if (be[0]) m_mb[3:0]  = d[7:4];
        if (be[1]) m_mb[11:4] = d[15:8];
        if (be[2]) m_ml[3:0]  = d[23:20];
        if (be[3]) m_ml[11:4] = d[31:24];
      end
      6'd15: if (be[2]) begin m_rst = d[22]; m_vga = d[19]; m_isa = d[18]; end
      default: ;
    endcase
  endtask

  // one cycle: drive after negedge, check before posedge, update model after it
  task automatic step(input logic wr, input logic [5:0] dw, input logic [3:0] be,
                      input logic [31:0] d, input logic v, input logic [1:0] t,
                      input logic [31:0] a, input logic [7:0] b, input string tag);
    logic ef;
    logic [1:0] ec;
    @(negedge clk_i);
    cfg_wr_i = wr; cfg_dw_i = dw; cfg_be_i = be; cfg_wdata_i = d;
    req_valid_i = v; req_type_i = t; req_addr_i = a; req_bus_i = b;
    #1;
    ef = exp_fwd(v, t, a);
    ec = exp_cfg(v, t, b);
    chk(fwd_o === ef, {tag, " fwd"}, {31'h0, fwd_o}, {31'h0, ef});
    chk({cfg_t1_o, cfg_t0_o} === ec, {tag, " cfg"}, {30'h0, cfg_t1_o, cfg_t0_o}, {30'h0, ec});
    chk(cfg_rdata_o === exp_rd(dw), {tag, " rd"}, cfg_rdata_o, exp_rd(dw));
    chk(sec_rst_o === m_rst, {tag, " R11 rst"}, {31'h0, sec_rst_o}, {31'h0, m_rst});
    @(posedge clk_i);
    if (wr) model_wr(dw, be, d);
  endtask

  task automatic wr(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
    step(1'b1, dw, be, d, 1'b0, 2'd3, 32'h0, 8'h0, "write");
  endtask

  task automatic rq(input logic [1:0] t, input logic [31:0] a, input logic [7:0] b, input string tag);
    step(1'b0, 6'd0, 4'h0, 32'h0, 1'b1, t, a, b, tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_cmd = 0; m_pri = 0; m_sec = 0; m_sub = 0; m_iob = 0; m_iol = 0;
    m_mb = 0; m_ml = 0; m_isa = 0; m_vga = 0; m_rst = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    for (int i = 0; i < 16; i++) begin
      step(1'b0, 6'(i), 4'h0, 32'h0, 1'b0, 2'd3, 32'h0, 8'h0, "R1 reset");
    end
    rq(2'd0, 32'h0, 8'h0, "R1 mem idle");
    rq(2'd1, 32'h0, 8'h0, "R1 io idle");
    rq(2'd2, 32'h0, 8'h0, "R1 cfg idle");

    // R2/R3 layout, byte enables and fixed nibbles
    wr(6'd6, 4'b0111, 32'hFF03_0100);
    step(1'b0, 6'd6, 4'h0, 32'h0, 1'b0, 2'd3, 32'h0, 8'h0, "R2 bus rd");
    wr(6'd6, 4'b0010, 32'h0000_0700);
    step(1'b0, 6'd6, 4'h0, 32'h0, 1'b0, 2'd3, 32'h0, 8'h0, "R2 be mask");
    wr(6'd6, 4'b0111, 32'h0003_0100);
    wr(6'd7, 4'b0011, 32'h0000_2F1F);
    step(1'b0, 6'd7, 4'h0, 32'h0, 1'b0, 2'd3, 32'h0, 8'h0, "R3 io nibble");
    wr(6'd8, 4'b1111, 32'h80FF_800F);
    step(1'b0, 6'd8, 4'h0, 32'h0, 1'b0, 2'd3, 32'h0, 8'h0, "R3 mem nibble");
    wr(6'd2, 4'b1111, 32'hFFFF_FFFF);
    step(1'b0, 6'd2, 4'h0, 32'h0, 1'b0, 2'd3, 32'h0, 8'h0, "R2 unused");

    // R4/R5 gated by enables
    rq(2'd0, 32'h8000_0000, 8'h0, "R4 mem disabled");
    wr(6'd1, 4'b0001, 32'h3);
    rq(2'd0, 32'h7FFF_FFFF, 8'h0, "R4 below");
    rq(2'd0, 32'h8000_0000, 8'h0, "R4 base");
    rq(2'd0, 32'h80FF_FFFF, 8'h0, "R4 top");
    rq(2'd0, 32'h8100_0000, 8'h0, "R4 above");
    rq(2'd1, 32'h0000_0FFF, 8'h0, "R5 below");
    rq(2'd1, 32'h0000_1000, 8'h0, "R5 base");
    rq(2'd1, 32'h0000_2FFF, 8'h0, "R5 top");
    rq(2'd1, 32'h0001_1000, 8'h0, "R5 upper bits");
    rq(2'd3, 32'h8000_0000, 8'h2, "R12 none type");

    // R9/R10 config routing
    rq(2'd2, 32'h0, 8'h1, "R9 t0");
    rq(2'd2, 32'h0, 8'h2, "R9 t1");
    rq(2'd2, 32'h0, 8'h3, "R9 t1 sub");
    rq(2'd2, 32'h0, 8'h4, "R9 beyond");
    rq(2'd2, 32'h0, 8'h0, "R9 primary");
    wr(6'd6, 4'b0001, 32'h0000_0005);
    rq(2'd2, 32'h0, 8'h1, "R10 sec le pri");
    wr(6'd6, 4'b0001, 32'h0000_0000);

    // R7/R8 alias and display
    wr(6'd15, 4'b0100, 32'h0004_0000);
    rq(2'd1, 32'h0000_1000, 8'h0, "R7 no alias");
    rq(2'd1, 32'h0000_1100, 8'h0, "R7 alias");
    rq(2'd1, 32'h0000_13C0, 8'h0, "R7 alias hi");
    rq(2'd1, 32'h0000_03C0, 8'h0, "R8 vga off");
    wr(6'd15, 4'b0100, 32'h004C_0000);
    rq(2'd1, 32'h0000_03C0, 8'h0, "R8 vga io");
    rq(2'd1, 32'h0000_03BC, 8'h0, "R8 vga gap");
    rq(2'd0, 32'h000A_0000, 8'h0, "R8 vga mem");
    rq(2'd0, 32'h000C_0000, 8'h0, "R8 vga mem end");
    wr(6'd15, 4'b0100, 32'h0);

    // R6 inverted windows
    wr(6'd8, 4'b1111, 32'h1000_2000);
    rq(2'd0, 32'h1800_0000, 8'h0, "R6 mem inverted");
    wr(6'd7, 4'b0011, 32'h0000_1040);
    rq(2'd1, 32'h0000_2000, 8'h0, "R6 io inverted");

    // R12 write and request in the same cycle: old values decide
    step(1'b1, 6'd8, 4'b1111, 32'h4000_4000, 1'b1, 2'd0, 32'h4000_0000, 8'h0, "R12 same cycle mem");
    rq(2'd0, 32'h4000_0000, 8'h0, "R12 after write mem");
    step(1'b1, 6'd6, 4'b0111, 32'h0009_0800, 1'b1, 2'd2, 32'h0, 8'h8, "R12 same cycle bus");
    rq(2'd2, 32'h0, 8'h8, "R12 after write bus");
    step(1'b0, 6'd0, 4'h0, 32'h0, 1'b0, 2'd0, 32'h4000_0000, 8'h8, "R12 invalid");

    // R11 secondary reset
    wr(6'd15, 4'b0100, 32'h0040_0000);
    rq(2'd3, 32'h0, 8'h0, "R11 set");
    wr(6'd15, 4'b0100, 32'h0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] dw;
      logic [31:0] a;
      logic [1:0] t;
      case ($urandom_range(0, 5))
        0: dw = 6'd1; 1: dw = 6'd6; 2: dw = 6'd7; 3: dw = 6'd8; 4: dw = 6'd15;
        default: dw = 6'($urandom_range(0, 63));
      endcase
      t = 2'($urandom_range(0, 3));
      a = $urandom();
      if (t == 2'd1 && $urandom_range(0, 3) != 0) a = {16'h0, a[15:0]};
      if (t == 2'd0 && $urandom_range(0, 3) == 0) a = {12'h0, 4'hA + 4'($urandom_range(0, 2)), a[15:0]};
      step($urandom_range(0, 2) == 0, dw, 4'($urandom()), $urandom(),
           $urandom_range(0, 4) != 0, t, a, 8'($urandom_range(0, 15)), "R4 R5 R9 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule